// File: doc/BRIEF.md
# Acknowledge Wait Jitter Controller

This block runs the sending station's side of a synchronous acknowledgement. Once the packet layer has put its last byte on the wire, it strobes `start_i`. The controller then alternates between two phases. In the first it drives a short high pulse, one quarter of a bit period long. In the second it releases the line and watches the byte receiver for a reply. The pulse train keeps the medium busy while the far end computes its CRC, so third parties do not see an idle line and start talking.

The wait ends in one of three ways:
- A clean reply byte arrives during a listen phase. It is classified as acknowledge (value 6), negative acknowledge (value 21) or protocol error (any other value).
- No clean byte arrives within a configurable number of cycles, and the block reports a timeout.
- In both cases the outcome is reported with a one-cycle done strobe and a held result code, and the line driver is released.

A small helper for the receiving station turns a CRC-ok flag into the reply byte on a request strobe. Byte serialization and CRC calculation live outside the block.

Top module: `ack_wait_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy_o`, `done_o`, `line_o`, `line_oe_o` and `reply_valid_o` are 0, and `result_o` is 0.
- R2: A `start_i` sampled while idle makes `busy_o` high from the next cycle. Busy cycle n (counting from 0) drives the pulse when (n mod (PULSE+LISTEN)) < PULSE, where PULSE = BIT_TICKS/4. In all other cycles `line_oe_o` is 0.
- R3: `line_o` is 1 exactly when `line_oe_o` is 1, so the line is only ever driven high.
- R4: A byte of value 6 with `rx_valid_i`=1 and `rx_err_i`=0 during a listen cycle ends the wait. On the next cycle `done_o`=1, `busy_o`=0 and `result_o`=0 (acknowledge).
- R5: A clean byte of value 21 during a listen cycle ends the wait with `result_o`=1 (negative acknowledge).
- R6: A clean byte of any value other than 6 or 21 during a listen cycle ends the wait with `result_o`=2 (protocol error).
- R7: A byte presented during a pulse cycle, or with `rx_err_i`=1, is ignored. The wait and the pulse train continue unchanged.
- R8: If no clean byte arrives during listen cycles 0 to WAIT_LIMIT-1, the wait ends in busy cycle WAIT_LIMIT-1. On the next cycle `done_o`=1, `result_o`=3 (timeout) and the line is released.
- R9: `start_i` while busy has no effect on the pulse train or on the timing of the outcome.
- R10: `done_o` is high for exactly one cycle per wait. `result_o` keeps its value until the next wait ends.
- R11: When `reply_req_i` is sampled high, on the next cycle `reply_valid_o`=1 for one cycle and `reply_byte_o` is 6 if `crc_ok_i` was 1, or 21 if it was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an acknowledge wait (packet just sent) |
| rx_byte_i | input | 8 | Byte from the byte receiver |
| rx_valid_i | input | 1 | `rx_byte_i` holds a received byte this cycle |
| rx_err_i | input | 1 | The received byte was corrupted by interference |
| line_o | output | 1 | Line output level |
| line_oe_o | output | 1 | Line output enable |
| busy_o | output | 1 | Wait in progress |
| done_o | output | 1 | One-cycle strobe: wait finished |
| result_o | output | 2 | 0 acknowledge, 1 negative acknowledge, 2 protocol error, 3 timeout |
| crc_ok_i | input | 1 | Responder: received packet passed its CRC |
| reply_req_i | input | 1 | Responder: request a reply byte |
| reply_byte_o | output | 8 | Responder: reply byte (6 or 21) |
| reply_valid_o | output | 1 | Responder: reply byte valid, one cycle |

## Verification
A phase counter that drifts shows up on `line_oe_o` within one pulse period. It shows as pulses that are too long, too short or out of place. It also shows as a reply accepted, or refused, in the wrong phase. A wrong wait counter moves the timeout strobe off cycle WAIT_LIMIT, which the per-cycle comparison catches on that exact cycle. A mis-decoded reply or a stuck busy flag appears on `result_o`, `done_o` or `busy_o` on the cycle after the reply byte.

// File: rtl/ack_wait_pkg.sv
// Shared codes and result encoding for the acknowledge wait controller.
// Assumes replies are single bytes on the same medium as the packet.
package ack_wait_pkg;
    localparam logic [7:0] CODE_ACK = 8'd6;
    localparam logic [7:0] CODE_NAK = 8'd21;

    typedef enum logic [1:0] {
        RES_ACK     = 2'd0,
        RES_NAK     = 2'd1,
        RES_PROTO   = 2'd2,
        RES_TIMEOUT = 2'd3
    } ack_res_e;
endpackage

// File: rtl/ack_phase_gen.sv
// Pulse/listen phase generator. Counts busy cycles modulo PULSE+LISTEN and
// reports the pulse phase. Assumes clear_i is given on the cycle a wait is
// accepted, so the first busy cycle is a pulse cycle.
module ack_phase_gen #(
    parameter int PULSE_TICKS  = 4,
    parameter int LISTEN_TICKS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic pulse_o
);
    localparam int PERIOD = PULSE_TICKS + LISTEN_TICKS;
    localparam int CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST_PH  = CW'(PERIOD - 1);
    localparam logic [CW-1:0] PULSE_CW = CW'(PULSE_TICKS);

    logic [CW-1:0] ph_q;

    // Phase counter: restart on clear, wrap at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n)          ph_q <= '0;
        else if (clear_i)    ph_q <= '0;
        else if (run_i)      ph_q <= (ph_q == LAST_PH) ? '0 : ph_q + 1'b1;
    end

    // Pulse phase is the first PULSE_TICKS counts of each period.
    assign pulse_o = (ph_q < PULSE_CW);
endmodule

// File: rtl/ack_wait_limit.sv
// Wait-limit counter. Counts busy cycles since the wait began and flags the
// last permitted cycle. Assumes the owner stops the wait when expire_o is seen.
module ack_wait_limit #(
    parameter int WAIT_LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int WW = (WAIT_LIMIT > 1) ? $clog2(WAIT_LIMIT) : 1;
    localparam logic [WW-1:0] LAST_CYC = WW'(WAIT_LIMIT - 1);

    logic [WW-1:0] cnt_q;

    // Elapsed-cycle counter: restart on clear, hold at the last count.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (clear_i)                   cnt_q <= '0;
        else if (run_i && cnt_q != LAST_CYC) cnt_q <= cnt_q + 1'b1;
    end

    // Last permitted busy cycle reached.
    assign expire_o = (cnt_q == LAST_CYC);
endmodule

// File: rtl/ack_reply_gen.sv
// Responder helper. On a request strobe it produces the acknowledge byte
// (CRC good) or the negative acknowledge byte (CRC bad) for one cycle.
// Assumes crc_ok_i is valid in the request cycle.
module ack_reply_gen
    import ack_wait_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       crc_ok_i,
    output logic [7:0] byte_o,
    output logic       valid_o
);
    // Register the reply code and its one-cycle valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= req_i;
            if (req_i) byte_o <= crc_ok_i ? CODE_ACK : CODE_NAK;
        end
    end
endmodule

// File: rtl/ack_wait_ctrl.sv
// Acknowledge wait jitter controller (top). After start_i it drives
// quarter-bit high pulses separated by listen windows. It accepts a clean
// reply byte only in a listen window, and reports acknowledge, negative
// acknowledge, protocol error or timeout. Assumes the receiver presents each
// byte for one cycle with rx_valid_i.
module ack_wait_ctrl
    import ack_wait_pkg::*;
#(
    parameter int BIT_TICKS    = 16,
    parameter int LISTEN_TICKS = 12,
    parameter int WAIT_LIMIT   = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] rx_byte_i,
    input  logic       rx_valid_i,
    input  logic       rx_err_i,
    output logic       line_o,
    output logic       line_oe_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [1:0] result_o,
    input  logic       crc_ok_i,
    input  logic       reply_req_i,
    output logic [7:0] reply_byte_o,
    output logic       reply_valid_o
);
    localparam int PULSE_TICKS = (BIT_TICKS / 4 > 0) ? BIT_TICKS / 4 : 1;

    logic     busy_q, done_q;
    ack_res_e res_q, res_d;
    logic     accept, pulse, expire, listen, hit, finish;

    ack_phase_gen #(.PULSE_TICKS(PULSE_TICKS), .LISTEN_TICKS(LISTEN_TICKS)) u_phase (
        .clk(clk), .rst_n(rst_n), .clear_i(accept), .run_i(busy_q), .pulse_o(pulse)
    );

    ack_wait_limit #(.WAIT_LIMIT(WAIT_LIMIT)) u_limit (
        .clk(clk), .rst_n(rst_n), .clear_i(accept), .run_i(busy_q), .expire_o(expire)
    );

    ack_reply_gen u_reply (
        .clk(clk), .rst_n(rst_n), .req_i(reply_req_i), .crc_ok_i(crc_ok_i),
        .byte_o(reply_byte_o), .valid_o(reply_valid_o)
    );

    // Wait control decode: accept only when idle, take a reply only while listening.
    always_comb begin
        accept = start_i && !busy_q;
        listen = busy_q && !pulse;
        hit    = listen && rx_valid_i && !rx_err_i;
        finish = busy_q && (hit || expire);
        if (!hit)                        res_d = RES_TIMEOUT;
        else if (rx_byte_i == CODE_ACK)  res_d = RES_ACK;
        else if (rx_byte_i == CODE_NAK)  res_d = RES_NAK;
        else                             res_d = RES_PROTO;
    end

    // Busy flag, done strobe and held result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            res_q  <= RES_ACK;
        end else begin
            done_q <= finish;
            if (accept)      busy_q <= 1'b1;
            else if (finish) busy_q <= 1'b0;
            if (finish)      res_q <= res_d;
        end
    end

    assign line_oe_o = busy_q && pulse;
    assign line_o    = line_oe_o;
    assign busy_o    = busy_q;
    assign done_o    = done_q;
    assign result_o  = res_q;
endmodule

// File: rtl/ack_wait_ctrl_chk.sv
// Assertion checker for ack_wait_ctrl, attached with bind below.
// Assumes the synchronous active-low reset of the block.
module ack_wait_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [7:0] rx_byte_i,
    input logic       rx_valid_i,
    input logic       line_o,
    input logic       line_oe_o,
    input logic       busy_o,
    input logic       done_o,
    input logic [1:0] result_o,
    input logic       reply_req_i,
    input logic [7:0] reply_byte_o,
    input logic       reply_valid_o
);
    p_oe_needs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe_o |-> busy_o);

    p_line_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        line_o |-> line_oe_o);

    p_ack_from_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o == 2'd0) |-> ($past(rx_valid_i) && $past(rx_byte_i) == 8'd6));

    p_nak_from_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o == 2'd1) |-> ($past(rx_valid_i) && $past(rx_byte_i) == 8'd21));

    p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !line_oe_o));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_result_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> (busy_o || done_o));

    p_reply_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reply_valid_o |-> (reply_byte_o == 8'd6 || reply_byte_o == 8'd21));

    p_reply_after_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reply_valid_o |-> $past(reply_req_i));
endmodule

bind ack_wait_ctrl ack_wait_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rx_byte_i(rx_byte_i),
    .rx_valid_i(rx_valid_i), .line_o(line_o), .line_oe_o(line_oe_o),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
    .reply_req_i(reply_req_i), .reply_byte_o(reply_byte_o),
    .reply_valid_o(reply_valid_o)
);

// File: tb/ack_wait_ctrl_tb_top.sv
// Bench for ack_wait_ctrl: a behavioural per-cycle model compared every clock,
// plus directed outcome checks.
module ack_wait_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BITT = 16;
    localparam int LSN  = 12;
    localparam int LIM  = 100;
    localparam int PUL  = BITT / 4;
    localparam int PER  = PUL + LSN;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 0, rx_valid_i = 0, rx_err_i = 0, crc_ok_i = 0, reply_req_i = 0;
    logic [7:0] rx_byte_i = 0;
    logic line_o, line_oe_o, busy_o, done_o, reply_valid_o;
    logic [1:0] result_o;
    logic [7:0] reply_byte_o;

    int checks = 0, fails = 0, cyc = 0;
    int m_busy = 0, m_n = 0, m_done = 0, m_res = 0, m_rv = 0, m_rb = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ack_wait_ctrl #(.BIT_TICKS(BITT), .LISTEN_TICKS(LSN), .WAIT_LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rx_byte_i(rx_byte_i),
        .rx_valid_i(rx_valid_i), .rx_err_i(rx_err_i), .line_o(line_o),
        .line_oe_o(line_oe_o), .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
        .crc_ok_i(crc_ok_i), .reply_req_i(reply_req_i), .reply_byte_o(reply_byte_o),
        .reply_valid_o(reply_valid_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic int classify(input int b);
        if (b == 6) return 0;
        if (b == 21) return 1;
        return 2;
    endfunction

    // Reference model: advance on each rising edge from the sampled inputs.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_n = 0; m_done = 0; m_res = 0; m_rv = 0; m_rb = 0;
        end else begin
            m_rv = reply_req_i;
            if (reply_req_i) m_rb = crc_ok_i ? 6 : 21;
            if (m_busy != 0) begin
                if ((m_n % PER) >= PUL && rx_valid_i && !rx_err_i) begin
                    m_busy = 0; m_done = 1; m_res = classify(rx_byte_i);
                end else if (m_n == LIM - 1) begin
                    m_busy = 0; m_done = 1; m_res = 3;
                end else begin
                    m_n++; m_done = 0;
                end
            end else begin
                m_done = 0;
                if (start_i) begin m_busy = 1; m_n = 0; end
            end
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int exp_oe;
            exp_oe = (m_busy != 0 && (m_n % PER) < PUL) ? 1 : 0;
            chk(line_oe_o == exp_oe, "R2 line_oe", line_oe_o, exp_oe);
            chk(line_o == exp_oe, "R3 line", line_o, exp_oe);
            chk(busy_o == m_busy, "R9 busy", busy_o, m_busy);
            chk(done_o == m_done, "R10 done", done_o, m_done);
            chk(result_o == m_res, "R10 result", result_o, m_res);
            chk(reply_valid_o == m_rv, "R11 reply_valid", reply_valid_o, m_rv);
            if (m_rv != 0) chk(reply_byte_o == m_rb, "R11 reply_byte", reply_byte_o, m_rb);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 20000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Start a wait; returns in busy cycle 0.
    task automatic go();
        start_i = 1; tick(1); start_i = 0;
    endtask

    // Present one byte at the current busy cycle.
    task automatic send(input logic [7:0] b, input logic err);
        rx_byte_i = b; rx_valid_i = 1; rx_err_i = err; tick(1);
        rx_valid_i = 0; rx_err_i = 0;
    endtask

    task automatic wait_done(output int cycles);
        cycles = 0;
        while (!done_o && cycles < 400) begin tick(1); cycles++; end
    endtask

    initial begin
        int c;
        tick(2);
        chk(busy_o == 0 && done_o == 0, "R1 busy/done in reset", busy_o + done_o, 0);
        chk(line_oe_o == 0 && line_o == 0, "R1 line in reset", line_oe_o + line_o, 0);
        chk(result_o == 0 && reply_valid_o == 0, "R1 result/reply in reset", result_o, 0);
        rst_n = 1; tick(1);
        chk(busy_o == 0 && line_oe_o == 0, "R1 after release", busy_o, 0);

        // R4 acknowledge in a listen cycle
        go(); tick(PUL + 2); send(8'd6, 0);
        chk(done_o == 1 && result_o == 0, "R4 ack result", result_o, 0);
        chk(busy_o == 0 && line_oe_o == 0, "R4 line released", line_oe_o, 0);
        tick(3);
        chk(result_o == 0, "R10 result held", result_o, 0);

        // R5 negative acknowledge in the second period's listen window
        go(); tick(PER + PUL); send(8'd21, 0);
        chk(done_o == 1 && result_o == 1, "R5 nak result", result_o, 1);
        tick(2);

        // R6 foreign byte
        go(); tick(PUL); send(8'h55, 0);
        chk(done_o == 1 && result_o == 2, "R6 protocol error", result_o, 2);
        tick(2);

        // R7/R9/R8: byte in pulse, error byte, start while busy, then timeout
        go(); tick(1); send(8'd6, 0);
        chk(busy_o == 1 && done_o == 0, "R7 pulse-phase byte ignored", busy_o, 1);
        tick(PUL); send(8'd6, 1);
        chk(busy_o == 1 && done_o == 0, "R7 error byte ignored", busy_o, 1);
        start_i = 1; tick(1); start_i = 0;
        chk(busy_o == 1, "R9 start while busy", busy_o, 1);
        wait_done(c);
        chk(done_o == 1 && result_o == 3, "R8 timeout result", result_o, 3);
        chk(c + PUL + 4 == LIM, "R8 timeout cycle", c + PUL + 4, LIM);
        tick(1);
        chk(done_o == 0, "R10 done single", done_o, 0);

        // R11 responder helper
        crc_ok_i = 1; reply_req_i = 1; tick(1); reply_req_i = 0;
        chk(reply_valid_o == 1 && reply_byte_o == 8'd6, "R11 ack byte", reply_byte_o, 6);
        crc_ok_i = 0; reply_req_i = 1; tick(1); reply_req_i = 0;
        chk(reply_valid_o == 1 && reply_byte_o == 8'd21, "R11 nak byte", reply_byte_o, 21);
        tick(1);
        chk(reply_valid_o == 0, "R11 valid single", reply_valid_o, 0);

        tick(2);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule